// File: doc/BRIEF.md
# Associative Named-Operand Store

This block is a small, fully associative buffer for the named scalar operands that a processor uses most often. A requester presents an operand address, with or without write data. The address is compared against every resident line in one cycle. On a match, a read returns the stored value and a write merges the new bytes into it. Neither case touches backing memory, and the reply comes one cycle after the request is accepted.

When no line matches, the block takes the line named by a cyclic replacement pointer. If a store order has modified that line, its old address and value are written back to memory first. The block then reads the requested operand from memory and installs the returned value together with its address. For a write request, the write bytes are merged into the filled value before it is installed, and the line is marked modified. Only one memory transaction is in flight at a time, and new requests are held off until the miss has been resolved.

Top module: `nos_store`

## Requirements
- R1: A read request that matches a resident line is answered in the cycle after acceptance with `rsp_valid`=1, `rsp_hit`=1 and the stored value, and no memory request is raised.
- R2: At most one line matches any address, and a lookup always returns the value most recently installed or written for that address.
- R3: A read miss raises a memory read (`mem_req_write`=0) for the requested address. When `mem_rsp_valid` arrives, the block installs the returned data and replies in the next cycle with `rsp_hit`=0 and that data.
- R4: After an address has been installed, further accesses to it are hits and cause no memory traffic until its line is replaced.
- R5: The victim pointer starts at line 0 and advances by one, wrapping at LINES-1, on every miss and on nothing else. Resident addresses are therefore displaced in the order in which they were installed, whatever their use.
- R6: When the victim line is invalid or unmodified, the miss issues only the memory read, with no write-back.
- R7: When the victim line is modified, a memory write (`mem_req_write`=1) of the victim's old address and current value is issued and accepted before the read.
- R8: A write hit merges `req_wdata` into the stored value, byte k taken from the write data when `req_wstrb[k]`=1. It marks the line modified, replies next cycle with `rsp_hit`=1 and the merged value, and makes no memory request.
- R9: A write miss fills the line from memory, then merges the write bytes into the returned value. It installs the merged value marked modified and replies with `rsp_hit`=0 and the merged value.
- R10: `req_ready` is low from the cycle after a miss is accepted until the miss is resolved. At most one memory transaction is outstanding, and `mem_req_valid`, `mem_req_write` and `mem_req_addr` hold steady until `mem_req_ready`.
- R11: After reset all lines are invalid, the pointer is at line 0, `req_ready`=1, and `mem_req_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write order, 0 = read |
| req_addr | input | AW | Operand address |
| req_wdata | input | DW | Write data |
| req_wstrb | input | DW/8 | Byte enables for the write |
| rsp_valid | output | 1 | One-cycle reply pulse |
| rsp_hit | output | 1 | Reply was served from a resident line |
| rsp_rdata | output | DW | Operand value after the access |
| mem_req_valid | output | 1 | Memory transaction requested |
| mem_req_ready | input | 1 | Memory accepts the transaction |
| mem_req_write | output | 1 | 1 = write-back, 0 = fill read |
| mem_req_addr | output | AW | Memory address |
| mem_req_wdata | output | DW | Write-back data |
| mem_rsp_valid | input | 1 | Fill data present |
| mem_rsp_rdata | input | DW | Fill data |

## Verification
A wrong tag or value in a line shows up at the next access to that address: a stale or corrupted `rsp_rdata`, or a hit flag where a miss was due. A missing or wrong modified bit shows up only later, when the victim pointer reaches that line. A write-back is then absent, spurious, or carries the wrong data, and a later re-fetch of the evicted address returns the wrong value. A drifting victim pointer changes which address a miss displaces. So the first wrong hit or miss can appear up to LINES misses after the fault, and the bench therefore runs past several full laps of the pointer.

// File: rtl/nos_pkg.sv
package nos_pkg;

  // Miss-handling sequence; the order is the order of the steps.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FETCH = 2'd2,
    ST_WAIT  = 2'd3
  } nos_state_e;

endpackage

// File: rtl/nos_match.sv
module nos_match #(
  parameter int LINES = 32,
  parameter int AW    = 16,
  parameter int IW    = 5
) (
  input  logic [AW-1:0]    key,
  input  logic [LINES-1:0] valid_vec,
  input  logic [AW-1:0]    tags [LINES],
  output logic [LINES-1:0] match_vec,
  output logic             hit,
  output logic [IW-1:0]    idx
);

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (tags[g] == key);
  end

  // OR-encode: at most one bit is set, so OR of indices is the index.
  always_comb begin
    idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (match_vec[i]) idx = idx | IW'(i);
    end
  end

  assign hit = |match_vec;

endmodule

// File: rtl/nos_victim.sv
module nos_victim #(
  parameter int LINES = 32,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [IW-1:0] ptr
);

  function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
    return (p == IW'(LINES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= step(ptr);
  end

endmodule

// File: rtl/nos_lines.sv
module nos_lines #(
  parameter int LINES = 32,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int IW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [IW-1:0]    upd_idx,
  input  logic [DW-1:0]    upd_data,
  input  logic             fill_en,
  input  logic [IW-1:0]    fill_idx,
  input  logic [AW-1:0]    fill_tag,
  input  logic [DW-1:0]    fill_data,
  input  logic             fill_dirty,
  output logic [LINES-1:0] valid_vec,
  output logic [LINES-1:0] dirty_vec,
  output logic [AW-1:0]    tags [LINES],
  output logic [DW-1:0]    data [LINES]
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic          v_q;
    logic          m_q;
    logic [AW-1:0] t_q;
    logic [DW-1:0] d_q;
    logic          sel_fill;
    logic          sel_upd;

    assign sel_fill = fill_en && (fill_idx == IW'(g));
    assign sel_upd  = upd_en  && (upd_idx  == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        m_q <= 1'b0;
      end else if (sel_fill) begin
        v_q <= 1'b1;
        m_q <= fill_dirty;
      end else if (sel_upd) begin
        m_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_fill) begin
        t_q <= fill_tag;
        d_q <= fill_data;
      end else if (sel_upd) begin
        d_q <= upd_data;
      end
    end

    assign valid_vec[g] = v_q;
    assign dirty_vec[g] = m_q;
    assign tags[g]      = t_q;
    assign data[g]      = d_q;
  end

endmodule

// File: rtl/nos_store.sv
module nos_store
  import nos_pkg::*;
#(
  parameter int LINES = 32,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_wstrb,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [DW-1:0]   rsp_rdata,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [AW-1:0]   mem_req_addr,
  output logic [DW-1:0]   mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_rdata
);

  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int SW = DW / 8;

  function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] base,
                                                input logic [DW-1:0] wdat,
                                                input logic [SW-1:0] strb);
    logic [DW-1:0] r;
    r = base;
    for (int b = 0; b < SW; b++) begin
      if (strb[b]) r[b*8 +: 8] = wdat[b*8 +: 8];
    end
    return r;
  endfunction

  nos_state_e state_q;

  logic [LINES-1:0] line_valid;
  logic [LINES-1:0] line_dirty;
  logic [AW-1:0]    line_tags [LINES];
  logic [DW-1:0]    line_data [LINES];

  logic [LINES-1:0] match_vec;
  logic             lk_hit;
  logic [IW-1:0]    lk_idx;
  logic [IW-1:0]    victim_ptr;

  logic            pend_write;
  logic [AW-1:0]   pend_addr;
  logic [DW-1:0]   pend_wdata;
  logic [SW-1:0]   pend_strb;
  logic [IW-1:0]   pend_idx;

  // Named internal events, also watched by the checker.
  logic            accept;
  logic            hit_evt;
  logic            miss_evt;
  logic            install_evt;
  logic            vic_dirty;
  logic [DW-1:0]   hit_value;
  logic [DW-1:0]   fill_value;

  assign req_ready   = (state_q == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign hit_evt     = accept && lk_hit;
  assign miss_evt    = accept && !lk_hit;
  assign install_evt = (state_q == ST_WAIT) && mem_rsp_valid;
  assign vic_dirty   = line_valid[victim_ptr] && line_dirty[victim_ptr];

  assign hit_value  = req_write ? merge_bytes(line_data[lk_idx], req_wdata, req_wstrb)
                                : line_data[lk_idx];
  assign fill_value = pend_write ? merge_bytes(mem_rsp_rdata, pend_wdata, pend_strb)
                                 : mem_rsp_rdata;

  assign mem_req_valid = (state_q == ST_EVICT) || (state_q == ST_FETCH);
  assign mem_req_write = (state_q == ST_EVICT);
  assign mem_req_addr  = (state_q == ST_EVICT) ? line_tags[pend_idx] : pend_addr;
  assign mem_req_wdata = line_data[pend_idx];

  nos_match #(.LINES(LINES), .AW(AW), .IW(IW)) u_match (
    .key       (req_addr),
    .valid_vec (line_valid),
    .tags      (line_tags),
    .match_vec (match_vec),
    .hit       (lk_hit),
    .idx       (lk_idx)
  );

  nos_victim #(.LINES(LINES), .IW(IW)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (miss_evt),
    .ptr     (victim_ptr)
  );

  nos_lines #(.LINES(LINES), .AW(AW), .DW(DW), .IW(IW)) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (hit_evt && req_write),
    .upd_idx    (lk_idx),
    .upd_data   (hit_value),
    .fill_en    (install_evt),
    .fill_idx   (pend_idx),
    .fill_tag   (pend_addr),
    .fill_data  (fill_value),
    .fill_dirty (pend_write),
    .valid_vec  (line_valid),
    .dirty_vec  (line_dirty),
    .tags       (line_tags),
    .data       (line_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pend_write <= 1'b0;
      pend_addr  <= '0;
      pend_wdata <= '0;
      pend_strb  <= '0;
      pend_idx   <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (hit_evt) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_rdata <= hit_value;
          end else if (miss_evt) begin
            pend_write <= req_write;
            pend_addr  <= req_addr;
            pend_wdata <= req_wdata;
            pend_strb  <= req_wstrb;
            pend_idx   <= victim_ptr;
            state_q    <= vic_dirty ? ST_EVICT : ST_FETCH;
          end
        end
        ST_EVICT: if (mem_req_ready) state_q <= ST_FETCH;
        ST_FETCH: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_rdata <= fill_value;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nos_store_chk.sv
module nos_store_chk #(
  parameter int LINES = 32,
  parameter int AW    = 16,
  parameter int IW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_write,
  input logic [AW-1:0]    mem_req_addr,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             hit_evt,
  input logic             miss_evt,
  input logic             install_evt,
  input logic             vic_dirty,
  input logic [LINES-1:0] match_vec,
  input logic [IW-1:0]    victim_ptr
);

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R2

  AST_HIT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> rsp_valid && rsp_hit && !mem_req_valid); // R1

  AST_FILL_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    install_evt |=> rsp_valid && !rsp_hit && req_ready); // R3

  AST_CLEAN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt && !vic_dirty |=> mem_req_valid && !mem_req_write); // R6

  AST_DIRTY_WB: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt && vic_dirty |=> mem_req_valid && mem_req_write); // R7

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R10

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr)); // R10

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> victim_ptr == (($past(victim_ptr) == IW'(LINES - 1)) ?
                                IW'(0) : IW'($past(victim_ptr) + 1'b1))); // R5

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_evt |=> $stable(victim_ptr)); // R5

endmodule

bind nos_store nos_store_chk #(.LINES(LINES), .AW(AW), .IW(IW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .hit_evt       (hit_evt),
  .miss_evt      (miss_evt),
  .install_evt   (install_evt),
  .vic_dirty     (vic_dirty),
  .match_vec     (match_vec),
  .victim_ptr    (victim_ptr)
);

// File: tb/tb_nos_store.sv
`timescale 1ns/1ps
module tb_nos_store;

  localparam int LINES = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_wstrb = '0;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [31:0] rsp_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [15:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  always #2.5 clk = ~clk;

  nos_store dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wstrb(req_wstrb),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;

  // Reference model: residents in install order, values and modified flags.
  int          res_q [$];
  logic [31:0] mval [int];
  bit          mdirty [int];
  logic [31:0] bmem [int];
  // Expected memory transactions.
  bit          ex_w [$];
  int          ex_a [$];
  logic [31:0] ex_d [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mem_rd(input int a);
    if (bmem.exists(a)) return bmem[a];
    return {16'(a) ^ 16'h5A5A, 16'(a)};
  endfunction

  function automatic logic [31:0] bmerge(input logic [31:0] o, input logic [31:0] n,
                                         input logic [3:0] s);
    logic [31:0] m;
    m = {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    return (o & ~m) | (n & m);
  endfunction

  function automatic bit resident(input int a);
    foreach (res_q[i]) if (res_q[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  // Memory responder with varying latency.
  int mem_cnt = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        int lat;
        bit w;
        int a;
        lat = mem_cnt % 3;
        repeat (lat) @(negedge clk);
        w = mem_req_write;
        a = int'(mem_req_addr);
        if (ex_w.size() == 0) begin
          chk(1'b0, "R10 unexpected memory request", 32'(a), 32'hFFFF_FFFF);
        end else begin
          bit ew;
          int ea;
          logic [31:0] ed;
          ew = ex_w.pop_front();
          ea = ex_a.pop_front();
          ed = ex_d.pop_front();
          chk(w == ew, ew ? "R7 write-back kind" : "R6 fill kind", 32'(w), 32'(ew));
          chk(a == ea, ew ? "R7 write-back address" : "R3 fill address",
              32'(a), 32'(ea));
          if (ew) chk(mem_req_wdata === ed, "R7 write-back data", mem_req_wdata, ed);
        end
        if (w) bmem[a] = mem_req_wdata;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (!w) begin
          repeat (lat) @(negedge clk);
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = mem_rd(a);
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end
        mem_cnt++;
      end
    end
  end

  // Per-clock port comparison.
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      chk(!(mem_req_valid && req_ready), "R10 ready during memory traffic",
          32'(req_ready), 32'h0);
    end
  end

  task automatic do_req(input bit wr, input int a, input logic [31:0] d,
                        input logic [3:0] s, input string tag);
    bit          hit;
    logic [31:0] expv;
    int          n;
    hit = resident(a);
    if (hit) begin
      expv = wr ? bmerge(mval[a], d, s) : mval[a];
      mval[a] = expv;
      if (wr) mdirty[a] = 1'b1;
    end else begin
      if (res_q.size() == LINES) begin
        int v;
        v = res_q.pop_front();
        if (mdirty[v]) begin
          ex_w.push_back(1'b1); ex_a.push_back(v); ex_d.push_back(mval[v]);
        end
        mval.delete(v);
        mdirty.delete(v);
      end
      ex_w.push_back(1'b0); ex_a.push_back(a); ex_d.push_back(32'h0);
      expv = mem_rd(a);
      if (wr) expv = bmerge(expv, d, s);
      res_q.push_back(a);
      mval[a] = expv;
      mdirty[a] = wr;
    end
    chk(req_ready === 1'b1, "R10 ready before request", 32'(req_ready), 32'h1);
    req_valid = 1'b1; req_write = wr; req_addr = 16'(a);
    req_wdata = d; req_wstrb = s;
    @(negedge clk);
    req_valid = 1'b0;
    if (hit) begin
      chk(rsp_valid === 1'b1, {tag, " reply one cycle after hit"}, 32'(rsp_valid), 32'h1);
    end else begin
      chk(!rsp_valid && !req_ready, "R10 stalled during miss",
          {30'h0, rsp_valid, req_ready}, 32'h0);
      n = 0;
      while (rsp_valid !== 1'b1 && n < 200) begin
        @(negedge clk);
        n++;
      end
      chk(rsp_valid === 1'b1, {tag, " miss reply"}, 32'(rsp_valid), 32'h1);
      chk(ex_w.size() == 0, "R3 memory transactions complete", 32'(ex_w.size()), 32'h0);
    end
    chk(rsp_hit === hit, {tag, " hit flag"}, 32'(rsp_hit), 32'(hit));
    chk(rsp_rdata === expv, {tag, " data"}, rsp_rdata, expv);
  endtask

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R11 ready in reset", 32'(req_ready), 32'h1);
    chk(mem_req_valid === 1'b0, "R11 no memory request", 32'(mem_req_valid), 32'h0);
    chk(rsp_valid === 1'b0, "R11 no reply", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    do_req(1'b0, 16'h0010, 32'h0, 4'h0, "R3");
    do_req(1'b0, 16'h0010, 32'h0, 4'h0, "R1");
    do_req(1'b0, 16'h0010, 32'h0, 4'h0, "R4");
    do_req(1'b1, 16'h0010, 32'hCAFE_BABE, 4'b0011, "R8");
    do_req(1'b0, 16'h0010, 32'h0, 4'h0, "R8");
    do_req(1'b1, 16'h0020, 32'h1234_5678, 4'b1100, "R9");
    do_req(1'b0, 16'h0020, 32'h0, 4'h0, "R9");
    for (int i = 0; i < 30; i++) do_req(1'b0, 16'h1000 + i, 32'h0, 4'h0, "R6");
    do_req(1'b0, 16'h2000, 32'h0, 4'h0, "R7");
    do_req(1'b0, 16'h0020, 32'h0, 4'h0, "R5");
    do_req(1'b0, 16'h2001, 32'h0, 4'h0, "R7");
    do_req(1'b0, 16'h2002, 32'h0, 4'h0, "R6");
    do_req(1'b0, 16'h0010, 32'h0, 4'h0, "R7");
    do_req(1'b0, 16'h0010, 32'h0, 4'h0, "R2");
    do_req(1'b0, 16'h1002, 32'h0, 4'h0, "R5");
    do_req(1'b0, 16'h1001, 32'h0, 4'h0, "R5");
    do_req(1'b1, 16'h1001, 32'hA5A5_0F0F, 4'b1111, "R8");

    seed = 7;
    for (int k = 0; k < 600; k++) begin
      int  a;
      bit  w;
      seed = seed * 1103515245 + 12345;
      a = 16'h3000 + ((seed >>> 8) & 32'h7FFF) % 40;
      w = ((seed >>> 20) & 3) == 0;
      do_req(w, a, 32'(seed) ^ 32'h0F1E_2D3C, 4'((seed >>> 4) & 15), "R4");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule